// File: doc/BRIEF.md
# Dual-Port Odd/Even Pixel Splitter

This block sits between a single-rate pixel stream and a pair of column-driver ports. Each input pixel is 18 bits (three 6-bit colour components) and is qualified by a data-enable. The block groups consecutive pixels of a line into pairs. The first pixel of each pair goes to the odd bus and the second to the even bus, and both halves of a pair leave on the same clock edge. The buses therefore carry the line at half the input rate.

Alongside the buses the block generates a half-rate driver clock, its inverted copy, and a horizontal start pulse. The start pulse is placed one driver-clock period ahead of the first pair of each line. A static strap input chooses whether the red and blue components keep their places or are exchanged on both buses. A line with an odd number of pixels is closed with a zero-filled even lane, so the last pixel still leaves.

Sequencing uses a three-state machine. `IDLE` waits for data-enable. The transition *line start* (data-enable high in `IDLE`) captures an odd pixel and enters `WANT_EVEN`. From `WANT_EVEN`, *pair complete* (enable high) captures the even pixel and enters `WANT_ODD`, while *pad close* (enable low) fills the even lane with zero and returns to `IDLE`. From `WANT_ODD`, *next odd* (enable high) re-enters `WANT_EVEN`, and *line end* (enable low) returns to `IDLE`. A completed pair is placed on the buses one input clock after it is completed.

Top module: `pixel_pair_splitter`

## Requirements
- R1: While `rst_n` is low at a rising edge, both buses are cleared to zero, `hstart` and `drv_clk` go low and `drv_clk_n` goes high.
- R2: Within a line, pixels 1, 3, 5, … appear on `odd_bus` and pixels 2, 4, 6, … on `even_bus`, and both buses of a pair change on the same edge.
- R3: If the first pixel of a line is sampled at rising edge n, the first pair is visible on the buses after edge n+2, and pair j (0-based) after edge n+2+2j.
- R4: `drv_clk` is high after the edge that samples the first pixel of a line and then toggles on every input edge. `drv_clk_n` is always its inverse. The buses change only on edges where `drv_clk` goes from low to high.
- R5: `hstart` is high for exactly two input cycles, after edge n and after edge n+1, so it falls on the edge that shows the first pair.
- R6: Pixel and bus layout is red in bits 17:12, green in 11:6 and blue in 5:0. With `swap_rb` = 1, the red and blue fields are exchanged on both buses. Green is never moved, and with `swap_rb` = 0 the fields pass unchanged.
- R7: When a line has an odd pixel count, its last pixel appears on `odd_bus` with `even_bus` all zero, at the time R3 gives for that pair.
- R8: While data-enable is low, the buses keep their last value and no start pulse begins.
- R9: Pairing restarts at each rising edge of data-enable, so the first pixel of every line goes to `odd_bus` even after an odd-length line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_de | input | 1 | Data-enable qualifying `pix_data` |
| pix_data | input | 18 | Input pixel {red, green, blue} |
| swap_rb | input | 1 | Strap: 0 keeps RGB order, 1 exchanges red and blue |
| drv_clk | output | 1 | Half-rate driver clock |
| drv_clk_n | output | 1 | Inverted copy of `drv_clk` |
| hstart | output | 1 | Horizontal start pulse, two input cycles wide |
| odd_bus | output | 18 | Odd-pixel column bus |
| even_bus | output | 18 | Even-pixel column bus |

## Verification
The properties assume that data-enable is low while reset is applied and that `swap_rb` is held steady around the edges where a pair is loaded. They also assume lines are separated by at least one low data-enable cycle, which keeps every bus load on a rising edge of `drv_clk`. The stimulus drives each line as a burst of enabled pixels followed by four idle cycles, and it changes the strap only between lines.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int unsigned PPS_COMP_W = 6;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_WANT_EVEN = 2'd1,
        PH_WANT_ODD  = 2'd2
    } pair_phase_e;

endpackage

// File: rtl/pps_pair_fsm.sv
module pps_pair_fsm
    import pps_pkg::*;
#(
    parameter int unsigned PIX_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de,
    input  logic [PIX_W-1:0] pix,
    output logic             line_start,
    output logic [PIX_W-1:0] odd_hold,
    output logic [PIX_W-1:0] even_hold,
    output logic             pair_rdy
);

    pair_phase_e state_q, state_d;
    logic        take_odd, take_even, pad_even;

    // next-state and transition decode
    always_comb begin
        state_d    = state_q;
        line_start = 1'b0;
        take_odd   = 1'b0;
        take_even  = 1'b0;
        pad_even   = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (de) begin
                    line_start = 1'b1;
                    take_odd   = 1'b1;
                    state_d    = PH_WANT_EVEN;
                end
            end
            PH_WANT_EVEN: begin
                if (de) begin
                    take_even = 1'b1;
                    state_d   = PH_WANT_ODD;
                end else begin
                    pad_even  = 1'b1;
                    state_d   = PH_IDLE;
                end
            end
            PH_WANT_ODD: begin
                if (de) begin
                    take_odd = 1'b1;
                    state_d  = PH_WANT_EVEN;
                end else begin
                    state_d  = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_hold  <= '0;
            even_hold <= '0;
            pair_rdy  <= 1'b0;
        end else begin
            if (take_odd)  odd_hold  <= pix;
            if (take_even) even_hold <= pix;
            else if (pad_even) even_hold <= '0;
            pair_rdy <= take_even | pad_even;
        end
    end

endmodule

// File: rtl/pps_clk_gen.sv
module pps_clk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic drv_clk,
    output logic hstart
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_clk <= 1'b0;
            hstart  <= 1'b0;
        end else begin
            drv_clk <= line_start ? 1'b1 : ~drv_clk;
            hstart  <= line_start | (hstart & drv_clk);
        end
    end

endmodule

// File: rtl/pps_lane_order.sv
module pps_lane_order #(
    parameter int unsigned COMP_W = 6,
    localparam int unsigned PIX_W = 3 * COMP_W
) (
    input  logic             swap,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_out
);

    logic [COMP_W-1:0] red_f, grn_f, blu_f;

    assign red_f = pix_in[3*COMP_W-1:2*COMP_W];
    assign grn_f = pix_in[2*COMP_W-1:COMP_W];
    assign blu_f = pix_in[COMP_W-1:0];

    always_comb begin
        if (swap) pix_out = {blu_f, grn_f, red_f};
        else      pix_out = {red_f, grn_f, blu_f};
    end

endmodule

// File: rtl/pixel_pair_splitter.sv
module pixel_pair_splitter
    import pps_pkg::*;
#(
    parameter int unsigned COMP_W = PPS_COMP_W,
    localparam int unsigned PIX_W = 3 * COMP_W,
    localparam int unsigned N_BUS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_de,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             swap_rb,
    output logic             drv_clk,
    output logic             drv_clk_n,
    output logic             hstart,
    output logic [PIX_W-1:0] odd_bus,
    output logic [PIX_W-1:0] even_bus
);

    logic             line_start;
    logic             pair_rdy;
    logic [PIX_W-1:0] odd_hold, even_hold;
    logic [PIX_W-1:0] lane_src [N_BUS];
    logic [PIX_W-1:0] lane_dst [N_BUS];

    pps_pair_fsm #(.PIX_W(PIX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .de         (pix_de),
        .pix        (pix_data),
        .line_start (line_start),
        .odd_hold   (odd_hold),
        .even_hold  (even_hold),
        .pair_rdy   (pair_rdy)
    );

    pps_clk_gen u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .drv_clk    (drv_clk),
        .hstart     (hstart)
    );

    assign drv_clk_n   = ~drv_clk;
    assign lane_src[0] = odd_hold;
    assign lane_src[1] = even_hold;

    for (genvar b = 0; b < N_BUS; b++) begin : g_lane
        pps_lane_order #(.COMP_W(COMP_W)) u_order (
            .swap    (swap_rb),
            .pix_in  (lane_src[b]),
            .pix_out (lane_dst[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_bus  <= '0;
            even_bus <= '0;
        end else if (pair_rdy) begin
            odd_bus  <= lane_dst[0];
            even_bus <= lane_dst[1];
        end
    end

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int unsigned PIX_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_de,
    input logic             drv_clk,
    input logic             hstart,
    input logic [PIX_W-1:0] odd_bus,
    input logic [PIX_W-1:0] even_bus
);

    assert_start_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hstart) |=> hstart);

    assert_start_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hstart && $past(hstart)) |=> !hstart);

    assert_start_clk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hstart) |-> drv_clk);

    assert_bus_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(odd_bus) || !$stable(even_bus)) |-> $rose(drv_clk));

    assert_no_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hstart) |-> $past(pix_de));

endmodule

bind pixel_pair_splitter pps_checker #(.PIX_W(PIX_W)) u_pps_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_de   (pix_de),
    .drv_clk  (drv_clk),
    .hstart   (hstart),
    .odd_bus  (odd_bus),
    .even_bus (even_bus)
);

// File: tb/pixel_pair_splitter_test.sv
module pixel_pair_splitter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_de = 1'b0;
    logic [17:0] pix_data = '0;
    logic        swap_rb = 1'b0;
    logic        drv_clk, drv_clk_n, hstart;
    logic [17:0] odd_bus, even_bus;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [35:0] exp_prev = '0;

    always #2 clk = ~clk;

    pixel_pair_splitter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_de    (pix_de),
        .pix_data  (pix_data),
        .swap_rb   (swap_rb),
        .drv_clk   (drv_clk),
        .drv_clk_n (drv_clk_n),
        .hstart    (hstart),
        .odd_bus   (odd_bus),
        .even_bus  (even_bus)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (act=%0d cycles, exp<20000)", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(string what, logic [35:0] act, logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [17:0] mk_pix(int base, int i);
        logic [5:0] r, g, b;
        r = 6'(base + i);
        g = 6'(i * 5 + 3);
        b = 6'(base * 3 + 7 - i);
        return {r, g, b};
    endfunction

    function automatic logic [17:0] order(logic [17:0] p, logic sw);
        return sw ? {p[5:0], p[11:6], p[17:12]} : p;
    endfunction

    // Drives one line of len pixels plus four idle cycles and checks every edge.
    task automatic run_line(int len, int base, logic sw, string tag);
        int npairs = (len + 1) / 2;
        swap_rb = sw;
        for (int t = 0; t < len + 4; t++) begin
            @(negedge clk);
            pix_de   = (t < len);
            pix_data = (t < len) ? mk_pix(base, t) : 18'h0;
            @(posedge clk);
            #1;
            chk($sformatf("R5 %s hstart t=%0d", tag, t), 36'(hstart), 36'(t < 2));
            chk($sformatf("R4 %s drv_clk t=%0d", tag, t), 36'({drv_clk, drv_clk_n}),
                (t % 2 == 0) ? 36'h2 : 36'h1);
            if (t >= 2 && t % 2 == 0 && (t / 2 - 1) < npairs) begin
                int j = t / 2 - 1;
                logic [17:0] eo, ee;
                eo = order(mk_pix(base, 2 * j), sw);
                ee = (2 * j + 1 < len) ? order(mk_pix(base, 2 * j + 1), sw) : 18'h0;
                exp_prev = {eo, ee};
                if (j == 0)
                    chk($sformatf("R3 R2 %s first pair", tag), {odd_bus, even_bus}, exp_prev);
                else if (2 * j + 1 >= len)
                    chk($sformatf("R7 %s padded pair %0d", tag, j), {odd_bus, even_bus}, exp_prev);
                else
                    chk($sformatf("R2 R6 %s pair %0d", tag, j), {odd_bus, even_bus}, exp_prev);
            end else begin
                chk($sformatf("R8 %s hold t=%0d", tag, t), {odd_bus, even_bus}, exp_prev);
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 buses", {odd_bus, even_bus}, 36'h0);
        chk("R1 clocks/start", 36'({drv_clk, drv_clk_n, hstart}), 36'b010);
        @(negedge clk);
        rst_n = 1'b1;
        exp_prev = '0;
        repeat (3) @(negedge clk);
        chk("R8 idle no start", 36'(hstart), 36'h0);
    endtask

    task automatic test_even_line();
        run_line(8, 4, 1'b0, "even");
    endtask

    task automatic test_swap();
        run_line(6, 17, 1'b1, "R6 swap");
    endtask

    task automatic test_odd_line();
        run_line(5, 33, 1'b0, "R7 odd");
    endtask

    task automatic test_restart();
        run_line(3, 9, 1'b1, "R9 pre");
        run_line(4, 50, 1'b0, "R9 restart");
    endtask

    task automatic test_single();
        run_line(1, 61, 1'b1, "R7 single");
    endtask

    initial begin
        test_reset();
        test_even_line();
        test_swap();
        test_odd_line();
        test_restart();
        test_single();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule